// File: doc/BRIEF.md
# Weighted Rate-Ceiling Egress Shaper

This block holds each queue of a multi-queue egress port to a fixed ceiling rate. Each queue has a small weight. The block divides every weight by the sum of all weights and rounds the result down to a 1/64 step of the link rate. That share becomes the number of bytes credited to the queue at each refill interval. A queue may start a packet only when its credit covers the full packet length. The length is subtracted at the moment the packet starts.

Credit never flows between queues. A queue that has run out of credit stays blocked even when the link is free and every other queue is empty, so its surplus stays in the upstream packet memory. This smooths the output over time instead of dropping traffic. When several queues can start in the same cycle, a rotating pointer picks the one that follows the queue that sent last. Packet storage and any strict-priority queue sit outside this block.

The upstream queue logic presents, for each queue, a "packet waiting" flag and the length of the head packet. It also reports whether the link can accept a new packet start. It then launches the head packet of whichever queue receives a one-cycle start permission.

Top module: `srr_shaper`

## Requirements
- R1: While `rst` is high no start permission is given. After reset every credit counter is zero, and the rotating pointer is placed so that queue 0 is examined first.
- R2: The credit added per refill interval to queue i is `floor(w_i*64/W) * (LINK_BYTES/64)` bytes, where `W` is the sum of all weights. When `W` is zero no queue receives credit, and a queue of weight zero never starts a packet.
- R3: A refill happens on every `REFILL_CYC`-th rising edge after reset is released. The first refill is on the `REFILL_CYC`-th edge, so a funded start can first appear `REFILL_CYC` cycles after release.
- R4: A credit counter never holds more than `MAX_FRAME` plus that queue's refill amount. An idle queue therefore cannot save up an unbounded burst.
- R5: Queue i is eligible only when its waiting flag is set, `link_idle` is high, and its credit is at least its head-packet length.
- R6: In the cycle a queue is granted, its head-packet length is subtracted from its credit at the next rising edge, together with any refill that lands on that same edge.
- R7: Among eligible queues, the grant goes to the first one found when searching upward (with wrap-around) from the queue after the one granted most recently.
- R8: At most one bit of `q_grant` is set in any cycle, and none is set while `link_idle` is low.
- R9: The bytes granted to a queue since reset never exceed its refill amount times the number of refills so far, whatever the other queues are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_ready | input | NQ | Per-queue head packet waiting |
| q_len | input | NQ*LW | Per-queue head-packet length in bytes; queue i at bits [i*LW +: LW] |
| q_weight | input | NQ*WW | Per-queue weight; queue i at bits [i*WW +: WW] |
| link_idle | input | 1 | Link can accept a packet start this cycle |
| q_grant | output | NQ | One-hot start permission, combinational from state and inputs |

## Verification
The bench sweeps pairs of weights across their range, plus a set of mixed four-queue weight sets. It compares every cycle's grant against an arithmetic model of the credit counters, the refill period and the rotating pointer.

Several corner cases get their own checks:
- **Saturation after a long idle spell.** The burst that follows must be exactly six 40-byte starts in twelve cycles. A missing ceiling would let the queue drain a large hoard of credit instead.
- **Zero weight sum and zero weights.** A divide that mishandled these would credit a queue that should be silent.
- **Timing of the first refill.** An off-by-one in the period counter shifts the first grant by a cycle.
- **Pointer update.** A pointer that failed to advance would starve queues 1 to 3 when all four are funded.
- **Long-run byte ceiling.** This catches a shaper that lends idle bandwidth to a busy queue.

// File: rtl/srr_pkg.sv
package srr_pkg;

    // Rate granularity: shares are counted in 1/64 steps of the link rate.
    localparam int unsigned GRAN_STEPS = 64;

    // Arbitration request for one queue.
    typedef struct packed {
        logic pending;   // head packet waiting
        logic funded;    // credit covers the head packet
    } qreq_t;

    // Normalised share in granularity steps, rounded down.
    function automatic int unsigned share_steps(input int unsigned w, input int unsigned total);
        if (total == 0) begin
            return 0;
        end
        return (w * GRAN_STEPS) / total;
    endfunction

endpackage

// File: rtl/srr_normalizer.sv
module srr_normalizer #(
    parameter int NQ         = 4,
    parameter int WW         = 4,
    parameter int LINK_BYTES = 512,
    parameter int AW         = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NQ*WW-1:0]  weights,
    output logic [NQ*AW-1:0]  refill_amt
);
    import srr_pkg::*;

    localparam int SW        = WW + $clog2(NQ) + 1;
    localparam int STEP_SIZE = LINK_BYTES / GRAN_STEPS;

    logic [SW-1:0]     wsum;
    logic [NQ*AW-1:0]  amt_n;

    always_comb begin
        wsum = '0;
        for (int i = 0; i < NQ; i++) begin
            wsum = wsum + SW'(weights[i*WW +: WW]);
        end
    end

    always_comb begin
        amt_n = '0;
        for (int i = 0; i < NQ; i++) begin
            amt_n[i*AW +: AW] = AW'(share_steps(32'(weights[i*WW +: WW]), 32'(wsum)) * STEP_SIZE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            refill_amt <= '0;
        end else begin
            refill_amt <= amt_n;
        end
    end

endmodule

// File: rtl/srr_bucket.sv
module srr_bucket #(
    parameter int TW        = 12,
    parameter int LW        = 11,
    parameter int AW        = 10,
    parameter int MAX_FRAME = 1518
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [AW-1:0]  amt,
    input  logic           take,
    input  logic [LW-1:0]  len,
    output logic [TW-1:0]  tok,
    output logic           funded
);
    localparam int CW = (TW > LW) ? TW : LW;

    logic [TW:0]   after_take;
    logic [TW:0]   after_fill;
    logic [TW:0]   ceiling;
    logic [TW-1:0] tok_n;

    assign funded = CW'(tok) >= CW'(len);

    always_comb begin
        after_take = {1'b0, tok} - (take ? (TW+1)'(len) : '0);
        after_fill = after_take + (tick ? (TW+1)'(amt) : '0);
        ceiling    = (TW+1)'(MAX_FRAME) + (TW+1)'(amt);
        tok_n      = (after_fill > ceiling) ? ceiling[TW-1:0] : after_fill[TW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tok <= '0;
        end else begin
            tok <= tok_n;
        end
    end

endmodule

// File: rtl/srr_rr_arb.sv
module srr_rr_arb #(
    parameter int NQ = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NQ-1:0] req,
    input  logic          en,
    output logic [NQ-1:0] gnt
);
    localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;

    logic [IW-1:0] last;
    logic [IW-1:0] win;
    logic          hit;

    always_comb begin
        int idx;
        gnt = '0;
        hit = 1'b0;
        win = last;
        for (int k = 1; k <= NQ; k++) begin
            idx = (int'(last) + k) % NQ;
            if (!hit && req[idx]) begin
                hit = 1'b1;
                win = IW'(idx);
            end
        end
        if (en && hit) begin
            gnt[win] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= IW'(NQ - 1);
        end else if (en && hit) begin
            last <= win;
        end
    end

endmodule

// File: rtl/srr_shaper.sv
module srr_shaper #(
    parameter int NQ         = 4,
    parameter int WW         = 4,
    parameter int LW         = 11,
    parameter int REFILL_CYC = 16,
    parameter int LINK_BYTES = 512,
    parameter int MAX_FRAME  = 1518
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NQ-1:0]     q_ready,
    input  logic [NQ*LW-1:0]  q_len,
    input  logic [NQ*WW-1:0]  q_weight,
    input  logic              link_idle,
    output logic [NQ-1:0]     q_grant
);
    import srr_pkg::*;

    localparam int AW = $clog2(LINK_BYTES + 1);
    localparam int TW = $clog2(MAX_FRAME + 2*LINK_BYTES + 1);
    localparam int PW = $clog2(REFILL_CYC);

    logic [PW-1:0]     period_cnt;
    logic              tick;
    logic [NQ*AW-1:0]  amt_flat;
    logic [NQ*TW-1:0]  tok_flat;
    logic [NQ-1:0]     funded;
    logic [NQ-1:0]     req_vec;
    qreq_t             req_s [NQ];

    assign tick = (period_cnt == PW'(REFILL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            period_cnt <= '0;
        end else begin
            period_cnt <= tick ? '0 : period_cnt + 1'b1;
        end
    end

    srr_normalizer #(.NQ(NQ), .WW(WW), .LINK_BYTES(LINK_BYTES), .AW(AW)) u_norm (
        .clk        (clk),
        .rst        (rst),
        .weights    (q_weight),
        .refill_amt (amt_flat)
    );

    for (genvar i = 0; i < NQ; i++) begin : g_q
        srr_bucket #(.TW(TW), .LW(LW), .AW(AW), .MAX_FRAME(MAX_FRAME)) u_bucket (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .amt    (amt_flat[i*AW +: AW]),
            .take   (q_grant[i]),
            .len    (q_len[i*LW +: LW]),
            .tok    (tok_flat[i*TW +: TW]),
            .funded (funded[i])
        );
        assign req_s[i].pending = q_ready[i];
        assign req_s[i].funded  = funded[i];
        assign req_vec[i]       = req_s[i].pending & req_s[i].funded;
    end

    srr_rr_arb #(.NQ(NQ)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (req_vec),
        .en  (link_idle & ~rst),
        .gnt (q_grant)
    );

endmodule

// File: rtl/srr_shaper_chk.sv
module srr_shaper_chk #(
    parameter int NQ         = 4,
    parameter int LW         = 11,
    parameter int TW         = 12,
    parameter int LINK_BYTES = 512,
    parameter int MAX_FRAME  = 1518
) (
    input logic              clk,
    input logic              rst,
    input logic [NQ-1:0]     q_ready,
    input logic [NQ*LW-1:0]  q_len,
    input logic              link_idle,
    input logic [NQ-1:0]     q_grant,
    input logic [NQ*TW-1:0]  tok_flat
);
    assert_one_start_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_grant));

    assert_busy_link_R8: assert property (@(posedge clk) disable iff (rst)
        !link_idle |-> (q_grant == '0));

    for (genvar i = 0; i < NQ; i++) begin : g_chk
        assert_pending_R5: assert property (@(posedge clk) disable iff (rst)
            q_grant[i] |-> q_ready[i]);

        assert_funded_R5: assert property (@(posedge clk) disable iff (rst)
            q_grant[i] |-> (int'(tok_flat[i*TW +: TW]) >= int'(q_len[i*LW +: LW])));

        assert_deduct_R6: assert property (@(posedge clk) disable iff (rst)
            q_grant[i] |=> (int'(tok_flat[i*TW +: TW]) + int'($past(q_len[i*LW +: LW]))
                            <= int'($past(tok_flat[i*TW +: TW])) + LINK_BYTES));

        assert_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
            int'(tok_flat[i*TW +: TW]) <= MAX_FRAME + LINK_BYTES);

        assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (tok_flat[i*TW +: TW] == '0));
    end

endmodule

bind srr_shaper srr_shaper_chk #(
    .NQ(NQ), .LW(LW), .TW(TW), .LINK_BYTES(LINK_BYTES), .MAX_FRAME(MAX_FRAME)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .q_ready   (q_ready),
    .q_len     (q_len),
    .link_idle (link_idle),
    .q_grant   (q_grant),
    .tok_flat  (tok_flat)
);

// File: tb/tb_srr_shaper.sv
`timescale 1ns/1ps
module tb_srr_shaper;
    localparam int NQ = 4, WW = 4, LW = 7, RC = 4, LB = 256, MF = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NQ-1:0] ready = '0;
    logic [LW-1:0] len [NQ];
    int   wcfg [NQ];
    logic [NQ*LW-1:0] len_flat;
    logic [NQ*WW-1:0] w_flat;
    logic link_idle = 1'b1;
    logic [NQ-1:0] q_grant;

    always #2 clk = ~clk;

    for (genvar i = 0; i < NQ; i++) begin : g_pack
        assign len_flat[i*LW +: LW] = len[i];
        assign w_flat[i*WW +: WW]   = WW'(wcfg[i]);
    end

    srr_shaper #(.NQ(NQ), .WW(WW), .LW(LW), .REFILL_CYC(RC), .LINK_BYTES(LB), .MAX_FRAME(MF)) dut (
        .clk(clk), .rst(rst), .q_ready(ready), .q_len(len_flat), .q_weight(w_flat),
        .link_idle(link_idle), .q_grant(q_grant)
    );

    int n_checks = 0, n_err = 0;
    int m_tok [NQ], m_amt [NQ], m_bytes [NQ];
    int m_ptr, m_cnt, m_ticks, cyc, first_gnt;
    int last_g;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 8);
    endfunction

    task automatic model_reset();
        int tot = 0;
        for (int i = 0; i < NQ; i++) tot += wcfg[i];
        for (int i = 0; i < NQ; i++) begin
            m_tok[i] = 0;
            m_bytes[i] = 0;
            m_amt[i] = (tot == 0) ? 0 : ((wcfg[i] * 64) / tot) * (LB / 64);
        end
        m_ptr = NQ - 1; m_cnt = 0; m_ticks = 0; cyc = 0; first_gnt = -1;
    endtask

    // Inputs are already driven; compare this cycle and advance the model.
    task automatic step();
        int g = -1;
        logic [NQ-1:0] e = '0;
        #1;
        if (link_idle) begin
            for (int k = 1; k <= NQ; k++) begin
                int idx;
                idx = (m_ptr + k) % NQ;
                if (g < 0 && ready[idx] && m_tok[idx] >= int'(len[idx])) g = idx;
            end
        end
        if (g >= 0) e[g] = 1'b1;
        chk(q_grant === e, "R5 R6 R7 R8 grant vector", int'(q_grant), int'(e));
        last_g = g;
        if (g >= 0) begin
            m_tok[g] -= int'(len[g]);
            m_bytes[g] += int'(len[g]);
            m_ptr = g;
            if (first_gnt < 0) first_gnt = cyc;
        end
        if (m_cnt == RC - 1) begin
            for (int i = 0; i < NQ; i++) m_tok[i] += m_amt[i];
            m_ticks++;
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
        for (int i = 0; i < NQ; i++)
            if (m_tok[i] > MF + m_amt[i]) m_tok[i] = MF + m_amt[i];
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ready = '1;
        link_idle = 1'b1;
        for (int i = 0; i < NQ; i++) len[i] = LW'(1);
        repeat (3) begin
            @(negedge clk);
            #1;
            chk(q_grant == '0, "R1 no grant in reset", int'(q_grant), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        ready = '0;
        model_reset();
    endtask

    task automatic run_random(input int ncyc, input int maxlen, input int dens);
        for (int c = 0; c < ncyc; c++) begin
            for (int i = 0; i < NQ; i++) begin
                ready[i] = (rnd() % 8) < dens;
                len[i] = LW'(1 + rnd() % maxlen);
            end
            link_idle = (rnd() % 8) != 0;
            step();
        end
    endtask

    task automatic end_of_run_checks();
        for (int i = 0; i < NQ; i++) begin
            chk(m_bytes[i] <= m_amt[i] * m_ticks, "R9 bytes within ceiling", m_bytes[i], m_amt[i] * m_ticks);
            if (wcfg[i] == 0) chk(m_bytes[i] == 0, "R2 zero weight silent", m_bytes[i], 0);
        end
    endtask

    initial begin
        int sets [8][NQ] = '{'{1,1,1,1}, '{15,0,0,0}, '{3,1,0,2}, '{0,0,0,0},
                             '{7,7,1,0}, '{1,2,4,8}, '{15,15,15,15}, '{5,0,9,0}};
        int cnt;
        for (int i = 0; i < NQ; i++) begin
            len[i] = LW'(1);
            wcfg[i] = 0;
        end

        // Near-exhaustive sweep over two-queue weight pairs.
        for (int a = 0; a < 16; a += 3) begin
            for (int b = 0; b < 16; b += 3) begin
                wcfg[0] = a; wcfg[1] = b; wcfg[2] = 0; wcfg[3] = 0;
                do_reset();
                run_random(100, MF, 6);
                end_of_run_checks();
            end
        end

        // Mixed four-queue weight sets.
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < NQ; i++) wcfg[i] = sets[s][i];
            do_reset();
            run_random(300, MF, 5);
            end_of_run_checks();
        end

        // R3: first refill lands on the RC-th edge after release.
        wcfg = '{15, 0, 0, 0};
        do_reset();
        ready = 4'b0001; len[0] = LW'(8);
        repeat (10) step();
        chk(first_gnt == RC, "R3 first grant cycle", first_gnt, RC);

        // R4: long idle spell, then 40-byte packets: cap 128, refill 64 per 4 cycles.
        wcfg = '{1, 1, 1, 1};
        do_reset();
        repeat (60) step();
        ready = 4'b0001; len[0] = LW'(40);
        cnt = 0;
        repeat (12) begin
            step();
            if (last_g == 0) cnt++;
        end
        chk(cnt == 6, "R4 burst after idle limited by ceiling", cnt, 6);

        // R7: all four funded equally; order after reset is 0,1,2,3,0,...
        wcfg = '{15, 15, 15, 15};
        do_reset();
        ready = '1;
        for (int i = 0; i < NQ; i++) len[i] = LW'(1);
        repeat (RC) step();
        for (int c = 0; c < 8; c++) begin
            step();
            chk(last_g == c % NQ, "R7 rotation order", last_g, c % NQ);
        end

        // R8: busy link blocks every start.
        link_idle = 1'b0;
        repeat (6) begin
            #1;
            chk(q_grant == '0, "R8 busy link", int'(q_grant), 0);
            step();
        end
        link_idle = 1'b1;

        // R2: weights 1:3 give 64 and 192 bytes per interval; 64-byte packets.
        wcfg = '{1, 3, 0, 0};
        do_reset();
        ready = 4'b0011; len[0] = LW'(64); len[1] = LW'(64);
        repeat (200) step();
        chk(m_bytes[0] >= 64 * (m_ticks - 3) && m_bytes[0] <= 64 * m_ticks,
            "R2 share of queue 0", m_bytes[0], 64 * m_ticks);
        chk(m_bytes[1] >= 192 * (m_ticks - 3) && m_bytes[1] <= 192 * m_ticks,
            "R2 share of queue 1", m_bytes[1], 192 * m_ticks);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule